// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block serves one transmit queue of a network controller. Software builds a circular list of 8-byte transmit descriptors in memory. Each descriptor holds a 16-bit flags word, a 16-bit byte count and a 32-bit buffer address. Software then pulses a start input. The engine reads each descriptor over a word-wide memory request port. For every descriptor that software has marked ready, it fetches the buffer bytes and streams them out on a byte-wide valid/ready port. When it has finished with a descriptor, it writes the descriptor's first word back with the hardware-owned status bits cleared.

A frame may span several descriptors and ends at the descriptor that carries the last flag. Options that apply to the whole frame are taken from the frame's first descriptor only:
- zero padding up to the minimum frame length;
- an 8-byte offload control block at the head of the frame, which is consumed and not transmitted.

Descriptors that carry the interrupt flag raise sticky event bits. When the walk arrives back at the ring base, the engine pulses `walk_done`, offers the ring base as the new current pointer and sets a halt bit in a status word.

Top module: `txr_ring_engine`

## Requirements
- R1: Descriptor word 0 holds the flags (bytes 0–1) and the length (bytes 2–3), and word 1 holds the buffer pointer. When `be_mode` is 0, each field is little-endian. When `be_mode` is 1, byte 0 is the most significant byte of each field. Write-back uses the same byte order.
- R2: A walk starts only on `kick` while `tx_en` is 1. It begins at `cur_ptr` with bits [2:0] cleared and steps the address by 8. A descriptor with flag bit 13 (wrap) set sends the next fetch to `ring_base` with bits [2:0] cleared. The walk ends when the next address equals that base. At that point `walk_done` pulses for one cycle and `ptr_next` shows the aligned base. Descriptors before the start address are left untouched.
- R3: A descriptor with bit 15 (ready) clear gets no data fetch and no write-back. A ready descriptor with length 0 also gets no data fetch, no write-back and no event.
- R4: Buffer bytes from the ready descriptors of one frame are sent in address order, using any byte alignment, up to the descriptor with bit 11 (last) set. `o_last` marks the final byte of each frame.
- R5: The frame is zero-padded to 64 sent bytes when either of these is 1 at the frame's first descriptor: bit 14 of that descriptor's flags, or the input `pad_all`.
- R6: If bit 1 is set in the frame's first descriptor, the first 8 bytes of the frame are not sent, and padding counts only the bytes that are sent. Bits 1 and 14 in later descriptors of the same frame have no effect.
- R7: Write-back rewrites word 0 of each processed descriptor with an unchanged length. It clears flag bits 15, 9, 8, 7, 5:2, 1 and 0, and keeps all other flag bits.
- R8: A processed descriptor with bit 12 (interrupt) set raises `evt_frame` if it has the last flag, and `evt_buf` otherwise. Both bits are sticky. A 1 on `evt_clr[1]` clears `evt_frame`, and a 1 on `evt_clr[0]` clears `evt_buf`. A set in the same cycle wins over a clear.
- R9: At the end of a walk, bit 31−RING_ID of `halt_stat` is set. It stays set until cleared by a 1 in the same position of `halt_clr`. A set in the same cycle wins.
- R10: A `kick` while `tx_en` is 0 causes no memory request, no output and no `walk_done`.
- R11: Memory requests are word-aligned. Each request is held with a stable address and write flag until `mem_ack`. An offered output byte is held stable until `o_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start-walk pulse |
| tx_en | input | 1 | Transmit enable |
| pad_all | input | 1 | Global pad enable |
| be_mode | input | 1 | Descriptor byte order: 1 = big-endian |
| ring_base | input | ADDR_W | Ring base address |
| cur_ptr | input | ADDR_W | Current descriptor address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address (byte units, bits [1:0] zero) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 32 | Read data, byte k at bits 8k+7:8k |
| o_valid | output | 1 | Output byte valid |
| o_data | output | 8 | Output byte |
| o_last | output | 1 | Final byte of frame |
| o_ready | input | 1 | Sink accepts byte |
| walk_done | output | 1 | One-cycle end-of-walk pulse |
| ptr_next | output | ADDR_W | New current pointer (aligned base) |
| evt_frame | output | 1 | Sticky frame event |
| evt_buf | output | 1 | Sticky buffer event |
| evt_clr | input | 2 | Write-ones clear: [1] frame, [0] buffer |
| halt_stat | output | 32 | Sticky halt status |
| halt_clr | input | 32 | Write-ones clear for halt_stat |

## Verification
Output bytes are recorded at the falling edge before the rising edge that accepts them, so the byte order is checked exactly and is independent of latency. The bench waits for `walk_done` and checks `ptr_next` in that same cycle. `halt_stat` is due one cycle after `walk_done` and is sampled at least two cycles later. Events are set at the write-back acknowledge, which always comes before `walk_done`, so they are checked after the walk.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int DESC_BYTES = 8;

    localparam int FB_READY   = 15;
    localparam int FB_PAD     = 14;
    localparam int FB_WRAP    = 13;
    localparam int FB_IRQ     = 12;
    localparam int FB_LAST    = 11;
    localparam int FB_OFFLOAD = 1;

    localparam logic [15:0] WB_CLEAR_MASK = 16'h83BF;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
        logic [31:0] ptr;
    } desc_t;

    typedef struct packed {
        logic offload;
        logic pad;
    } fopt_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD0,
        S_RD1,
        S_DRD,
        S_DOUT,
        S_PAD,
        S_WB,
        S_NEXT,
        S_DONE
    } st_t;

    function automatic logic [15:0] bswap16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    function automatic logic [31:0] bswap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/txr_desc_codec.sv
module txr_desc_codec
    import txr_pkg::*;
(
    input  logic        be_mode,
    input  logic [31:0] rd_w0,
    input  logic [31:0] rd_w1,
    output desc_t       dec,
    input  logic [15:0] wb_flags,
    input  logic [15:0] wb_len,
    output logic [31:0] wb_word
);
    always_comb begin
        if (be_mode) begin
            dec.flags = bswap16(rd_w0[15:0]);
            dec.len   = bswap16(rd_w0[31:16]);
            dec.ptr   = bswap32(rd_w1);
            wb_word   = {bswap16(wb_len), bswap16(wb_flags)};
        end else begin
            dec.flags = rd_w0[15:0];
            dec.len   = rd_w0[31:16];
            dec.ptr   = rd_w1;
            wb_word   = {wb_len, wb_flags};
        end
    end
endmodule

// File: rtl/txr_byte_pick.sv
module txr_byte_pick #(
    parameter int LANES = 4,
    localparam int LW = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] word,
    input  logic [LW-1:0]      lane,
    output logic [7:0]         byte_o
);
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/txr_sticky.sv
module txr_sticky #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         q[g] <= 1'b0;
            else if (set[g]) q[g] <= 1'b1;
            else if (clr[g]) q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/txr_ring_engine.sv
module txr_ring_engine
    import txr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int RING_ID   = 0,
    parameter int MIN_FRAME = 64,
    parameter int CB_BYTES  = 8,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic              tx_en,
    input  logic              pad_all,
    input  logic              be_mode,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [ADDR_W-1:0] cur_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              o_valid,
    output logic [7:0]        o_data,
    output logic              o_last,
    input  logic              o_ready,
    output logic              walk_done,
    output logic [ADDR_W-1:0] ptr_next,
    output logic              evt_frame,
    output logic              evt_buf,
    input  logic [1:0]        evt_clr,
    output logic [31:0]       halt_stat,
    input  logic [31:0]       halt_clr
);
    localparam int SN_W = $clog2(CB_BYTES + 1);
    localparam int HALT_BIT = 31 - RING_ID;
    localparam logic [31:0] HALT_MASK = 32'd1 << HALT_BIT;

    st_t               st_q;
    logic [ADDR_W-1:0] da_q;
    logic [ADDR_W-1:0] cur_a_q;
    logic [ADDR_W-1:0] base_al;
    logic [ADDR_W-1:0] nxt_a;
    logic [31:0]       w0_q;
    logic [31:0]       word_q;
    desc_t             dsc_q;
    desc_t             dec;
    fopt_t             fopt_q;
    logic              frame_open_q;
    logic              wrap_q;
    logic [15:0]       remain_q;
    logic [SN_W-1:0]   strip_q;
    logic [CNT_W-1:0]  sent_q;
    logic [CNT_W-1:0]  sent_nx;
    logic [CNT_W-1:0]  sent_after;
    logic [31:0]       wb_word;
    logic [7:0]        lane_byte;
    logic              dropping;
    logic              last_byte;
    logic              desc_last;
    logic              tail_pad;
    logic              byte_adv;
    logic              wb_ack;
    logic [1:0]        evt_set;
    logic [1:0]        evt_q;

    assign base_al   = {ring_base[ADDR_W-1:3], 3'b000};
    assign nxt_a     = wrap_q ? base_al : da_q + ADDR_W'(DESC_BYTES);
    assign desc_last = dsc_q.flags[FB_LAST];
    assign last_byte = (remain_q == 16'd1);
    assign dropping  = (st_q == S_DOUT) && fopt_q.offload && (strip_q < SN_W'(CB_BYTES));
    assign sent_nx   = (sent_q == {CNT_W{1'b1}}) ? sent_q : sent_q + 1'b1;
    assign sent_after = dropping ? sent_q : sent_nx;
    assign tail_pad  = fopt_q.pad && (32'(sent_after) < MIN_FRAME);
    assign byte_adv  = (st_q == S_DOUT) && (dropping || o_ready);
    assign wb_ack    = (st_q == S_WB) && mem_ack;

    txr_desc_codec u_codec (
        .be_mode (be_mode),
        .rd_w0   (w0_q),
        .rd_w1   (mem_rdata),
        .dec     (dec),
        .wb_flags(dsc_q.flags & ~WB_CLEAR_MASK),
        .wb_len  (dsc_q.len),
        .wb_word (wb_word)
    );

    txr_byte_pick #(.LANES(4)) u_pick (
        .word  (word_q),
        .lane  (cur_a_q[1:0]),
        .byte_o(lane_byte)
    );

    // memory request side
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = wb_word;
        unique case (st_q)
            S_RD0: begin
                mem_req  = 1'b1;
                mem_addr = da_q;
            end
            S_RD1: begin
                mem_req  = 1'b1;
                mem_addr = {da_q[ADDR_W-1:3], 3'b100};
            end
            S_DRD: begin
                mem_req  = 1'b1;
                mem_addr = {cur_a_q[ADDR_W-1:2], 2'b00};
            end
            S_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = da_q;
            end
            default: ;
        endcase
    end

    // byte output side
    always_comb begin
        o_valid = 1'b0;
        o_data  = 8'h00;
        o_last  = 1'b0;
        if (st_q == S_DOUT && !dropping) begin
            o_valid = 1'b1;
            o_data  = lane_byte;
            o_last  = last_byte && desc_last && !tail_pad;
        end else if (st_q == S_PAD) begin
            o_valid = 1'b1;
            o_last  = (32'(sent_nx) >= MIN_FRAME);
        end
    end

    assign walk_done = (st_q == S_DONE);
    assign ptr_next  = base_al;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= S_IDLE;
            da_q         <= '0;
            cur_a_q      <= '0;
            w0_q         <= '0;
            word_q       <= '0;
            dsc_q        <= '0;
            fopt_q       <= '0;
            frame_open_q <= 1'b0;
            wrap_q       <= 1'b0;
            remain_q     <= '0;
            strip_q      <= '0;
            sent_q       <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (kick && tx_en) begin
                        da_q <= {cur_ptr[ADDR_W-1:3], 3'b000};
                        st_q <= S_RD0;
                    end
                end
                S_RD0: begin
                    if (mem_ack) begin
                        w0_q <= mem_rdata;
                        st_q <= S_RD1;
                    end
                end
                S_RD1: begin
                    if (mem_ack) begin
                        wrap_q <= dec.flags[FB_WRAP];
                        if (!dec.flags[FB_READY] || dec.len == 16'd0) begin
                            st_q <= S_NEXT;
                        end else begin
                            dsc_q    <= dec;
                            cur_a_q  <= dec.ptr[ADDR_W-1:0];
                            remain_q <= dec.len;
                            if (!frame_open_q) begin
                                frame_open_q   <= 1'b1;
                                fopt_q.offload <= dec.flags[FB_OFFLOAD];
                                fopt_q.pad     <= dec.flags[FB_PAD] | pad_all;
                                sent_q         <= '0;
                                strip_q        <= '0;
                            end
                            st_q <= S_DRD;
                        end
                    end
                end
                S_DRD: begin
                    if (mem_ack) begin
                        word_q <= mem_rdata;
                        st_q   <= S_DOUT;
                    end
                end
                S_DOUT: begin
                    if (byte_adv) begin
                        cur_a_q  <= cur_a_q + 1'b1;
                        remain_q <= remain_q - 16'd1;
                        if (dropping) strip_q <= strip_q + 1'b1;
                        else          sent_q  <= sent_nx;
                        if (last_byte)
                            st_q <= (desc_last && tail_pad) ? S_PAD : S_WB;
                        else if (cur_a_q[1:0] == 2'b11)
                            st_q <= S_DRD;
                    end
                end
                S_PAD: begin
                    if (o_ready) begin
                        sent_q <= sent_nx;
                        if (32'(sent_nx) >= MIN_FRAME) st_q <= S_WB;
                    end
                end
                S_WB: begin
                    if (mem_ack) begin
                        if (desc_last) frame_open_q <= 1'b0;
                        st_q <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    da_q <= nxt_a;
                    st_q <= (nxt_a == base_al) ? S_DONE : S_RD0;
                end
                S_DONE: st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign evt_set[1] = wb_ack && dsc_q.flags[FB_IRQ] && desc_last;
    assign evt_set[0] = wb_ack && dsc_q.flags[FB_IRQ] && !desc_last;

    txr_sticky #(.W(2)) u_evt (
        .clk(clk), .rst(rst), .set(evt_set), .clr(evt_clr), .q(evt_q)
    );
    assign evt_frame = evt_q[1];
    assign evt_buf   = evt_q[0];

    txr_sticky #(.W(32)) u_halt (
        .clk(clk), .rst(rst),
        .set(walk_done ? HALT_MASK : 32'd0),
        .clr(halt_clr), .q(halt_stat)
    );
endmodule

// File: rtl/txr_ring_engine_chk.sv
module txr_ring_engine_chk #(
    parameter int ADDR_W  = 32,
    parameter int RING_ID = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              o_valid,
    input logic [7:0]        o_data,
    input logic              o_last,
    input logic              o_ready,
    input logic              walk_done,
    input logic              evt_frame,
    input logic              evt_buf,
    input logic [1:0]        evt_clr,
    input logic [31:0]       halt_stat
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00); // R11
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_last)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done); // R2
    AST_HALT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> halt_stat[31-RING_ID]); // R9
    AST_EVT_FRAME_STICKY: assert property (@(posedge clk) disable iff (rst)
        evt_frame && !evt_clr[1] |=> evt_frame); // R8
    AST_EVT_BUF_STICKY: assert property (@(posedge clk) disable iff (rst)
        evt_buf && !evt_clr[0] |=> evt_buf); // R8
endmodule

bind txr_ring_engine txr_ring_engine_chk #(.ADDR_W(ADDR_W), .RING_ID(RING_ID)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .o_valid(o_valid), .o_data(o_data), .o_last(o_last),
    .o_ready(o_ready), .walk_done(walk_done), .evt_frame(evt_frame), .evt_buf(evt_buf),
    .evt_clr(evt_clr), .halt_stat(halt_stat)
);

// File: tb/txr_ring_engine_bench.sv
module txr_ring_engine_bench;
    localparam int RING_ID = 2;

    logic        clk = 1'b0;
    logic        rst, kick, tx_en, pad_all, be_mode;
    logic [31:0] ring_base, cur_ptr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        o_valid, o_last, o_ready;
    logic [7:0]  o_data;
    logic        walk_done, evt_frame, evt_buf;
    logic [31:0] ptr_next, halt_stat, halt_clr;
    logic [1:0]  evt_clr;

    always #5 clk = ~clk;

    txr_ring_engine #(.RING_ID(RING_ID)) u_txr_ring_engine (
        .clk(clk), .rst(rst), .kick(kick), .tx_en(tx_en), .pad_all(pad_all),
        .be_mode(be_mode), .ring_base(ring_base), .cur_ptr(cur_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .o_valid(o_valid), .o_data(o_data),
        .o_last(o_last), .o_ready(o_ready), .walk_done(walk_done), .ptr_next(ptr_next),
        .evt_frame(evt_frame), .evt_buf(evt_buf), .evt_clr(evt_clr),
        .halt_stat(halt_stat), .halt_clr(halt_clr)
    );

    logic [7:0] mem  [4096];
    logic [7:0] rmem [4096];
    logic [8:0] got_q [$];
    logic [8:0] exp_q [$];
    int n_chk = 0, n_bad = 0, misalign = 0, req_cnt = 0, dly = 0, done_cnt = 0;
    bit m_open = 0, m_off = 0, m_pad = 0, m_ef = 0, m_eb = 0;
    int m_sent = 0, m_strip = 0;
    bit reported = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // memory model and output sink, all driven at the falling edge
    initial begin
        mem_ack = 0; mem_rdata = 0; o_ready = 0;
        forever begin
            @(negedge clk);
            o_ready = ($urandom % 4) != 0;
            if (o_valid && o_ready) got_q.push_back({o_last, o_data});
            if (walk_done) done_cnt++;
            if (mem_req) begin
                req_cnt++;
                if (mem_addr[1:0] != 2'b00) misalign++;
            end
            if (mem_ack) mem_ack = 0;
            else if (mem_req) begin
                if (dly > 0) dly--;
                else begin
                    if (mem_we) begin
                        for (int k = 0; k < 4; k++) mem[(mem_addr + k) & 32'hFFF] = mem_wdata[8*k +: 8];
                    end else begin
                        for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = mem[(mem_addr + k) & 32'hFFF];
                    end
                    mem_ack = 1;
                    dly = $urandom % 3;
                end
            end
        end
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    function automatic logic [15:0] get16(input int a, input bit be);
        return be ? {rmem[a & 4095], rmem[(a + 1) & 4095]} : {rmem[(a + 1) & 4095], rmem[a & 4095]};
    endfunction
    function automatic logic [31:0] get32(input int a, input bit be);
        return be ? {get16(a, 1), get16(a + 2, 1)} : {get16(a + 2, 0), get16(a, 0)};
    endfunction
    task automatic put16(input int a, input logic [15:0] v, input bit be);
        rmem[a & 4095]       = be ? v[15:8] : v[7:0];
        rmem[(a + 1) & 4095] = be ? v[7:0]  : v[15:8];
        mem[a & 4095]        = rmem[a & 4095];
        mem[(a + 1) & 4095]  = rmem[(a + 1) & 4095];
    endtask
    task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] ln,
                            input logic [31:0] p, input bit be);
        put16(a, fl, be); put16(a + 2, ln, be);
        put16(a + 4, be ? p[31:16] : p[15:0], be);
        put16(a + 6, be ? p[15:0] : p[31:16], be);
    endtask

    // expected behaviour from the requirements, on the shadow memory
    task automatic model_walk(input int base, input int start, input bit be, input bit pall);
        int a, b;
        logic [15:0] fl, ln;
        logic [31:0] p;
        a = start & ~7; b = base & ~7;
        do begin
            fl = get16(a, be); ln = get16(a + 2, be); p = get32(a + 4, be);
            if (fl[15] && ln != 0) begin
                if (!m_open) begin
                    m_open = 1; m_off = fl[1]; m_pad = fl[14] | pall; m_sent = 0; m_strip = 0;
                end
                for (int i = 0; i < int'(ln); i++) begin
                    if (m_off && m_strip < 8) m_strip++;
                    else begin
                        exp_q.push_back({1'b0, rmem[(p + i) & 4095]});
                        m_sent++;
                    end
                end
                if (fl[11]) begin
                    if (m_pad) while (m_sent < 64) begin exp_q.push_back(9'h000); m_sent++; end
                    if (m_sent > 0) exp_q[exp_q.size() - 1][8] = 1'b1;
                    m_open = 0;
                end
                if (fl[12]) begin
                    if (fl[11]) m_ef = 1; else m_eb = 1;
                end
                put16(a, fl & ~16'h83BF, be);
                put16(a, fl, be);
                rmem[a & 4095]       = be ? (fl[15:8] & 8'h7C) : (fl[7:0] & 8'h40);
                rmem[(a + 1) & 4095] = be ? (fl[7:0] & 8'h40)  : (fl[15:8] & 8'h7C);
            end
            a = fl[13] ? b : a + 8;
        end while (a != b);
    endtask

    task automatic run_walk(input int base, input int start, input bit be, input bit pall, input string req);
        int t, nmis;
        bit ok;
        got_q.delete(); exp_q.delete(); m_ef = 0; m_eb = 0;
        @(negedge clk);
        ring_base = base; cur_ptr = start; be_mode = be; pad_all = pall; tx_en = 1;
        model_walk(base, start, be, pall);
        kick = 1; @(negedge clk); kick = 0;
        t = 0;
        while (!walk_done && t < 20000) begin @(negedge clk); t++; end
        chk(walk_done == 1'b1, "R2", "walk_done reached", walk_done, 1);
        chk(ptr_next == (base & ~7), "R2", "ptr_next", ptr_next, base & ~7);
        repeat (3) @(negedge clk);
        chk(got_q.size() == exp_q.size(), req, "byte count", got_q.size(), exp_q.size());
        ok = 1;
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) if (got_q[i] != exp_q[i]) ok = 0;
        chk(ok, req, "frame bytes and last markers", 0, 0);
        nmis = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== rmem[i]) nmis++;
        chk(nmis == 0, "R7", "memory bytes differing after write-back", nmis, 0);
        chk(evt_frame == m_ef, "R8", "evt_frame", evt_frame, m_ef);
        chk(evt_buf == m_eb, "R8", "evt_buf", evt_buf, m_eb);
        chk(halt_stat == (32'd1 << (31 - RING_ID)), "R9", "halt_stat", halt_stat, 32'd1 << (31 - RING_ID));
        evt_clr = 2'b11; halt_clr = 32'hFFFF_FFFF;
        @(negedge clk);
        evt_clr = 2'b00; halt_clr = 0;
        @(negedge clk);
        chk({evt_frame, evt_buf} == 2'b00, "R8", "events after clear", {evt_frame, evt_buf}, 0);
        chk(halt_stat == 0, "R9", "halt after clear", halt_stat, 0);
    endtask

    initial begin
        logic [15:0] w;
        void'($urandom(32'd20240611));
        rst = 1; kick = 0; tx_en = 0; pad_all = 0; be_mode = 0;
        ring_base = 0; cur_ptr = 0; evt_clr = 0; halt_clr = 0;
        for (int i = 0; i < 4096; i++) begin mem[i] = $urandom; rmem[i] = mem[i]; end
        for (int i = 0; i < 512; i++) begin mem[i] = 0; rmem[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(o_valid == 0 && mem_req == 0, "R11", "reset outputs idle", {o_valid, mem_req}, 0);
        chk({evt_frame, evt_buf} == 0 && halt_stat == 0, "R9", "reset status", halt_stat, 0);

        // R10: disabled kick
        req_cnt = 0; done_cnt = 0;
        tx_en = 0; kick = 1; @(negedge clk); kick = 0;
        repeat (30) @(negedge clk);
        chk(req_cnt == 0 && done_cnt == 0 && got_q.size() == 0, "R10", "activity while disabled",
            req_cnt + done_cnt, 0);

        // directed little-endian ring at 0
        put_desc(0,  16'hD800 | 16'h4000, 16'd20, 32'd1025, 0); // ready pad irq last
        put_desc(8,  16'h0000 | 16'h03BD, 16'd10, 32'd1100, 0); // not ready
        put_desc(16, 16'h9000, 16'd0,  32'd1200, 0);            // ready, zero length, irq
        put_desc(24, 16'h9000, 16'd10, 32'd2001, 0);            // ready irq, open frame
        put_desc(32, 16'hF802, 16'd20, 32'd3003, 0);            // ready pad wrap irq last offload
        run_walk(0, 0, 0, 0, "R4");
        chk(got_q.size() == 94, "R5", "64 padded + 30 unpadded bytes", got_q.size(), 94);
        if (got_q.size() == 94) begin
            chk(got_q[63] == 9'h100, "R5", "pad tail byte", got_q[63], 9'h100);
            chk(got_q[19] == {1'b0, rmem[1044]}, "R4", "last data byte", got_q[19], rmem[1044]);
            chk(got_q[64] == {1'b0, rmem[2001]}, "R6", "later offload flag ignored", got_q[64], rmem[2001]);
            chk(got_q[93][8] == 1'b1, "R4", "o_last on final byte", got_q[93][8], 1);
        end
        w = {mem[9], mem[8]};
        chk(w == 16'h03BD, "R3", "non-ready descriptor untouched", w, 16'h03BD);
        w = {mem[17], mem[16]};
        chk(w == 16'h9000, "R3", "zero-length descriptor untouched", w, 16'h9000);

        // directed big-endian ring at 128, start mid ring with low bits set
        put_desc(128, 16'hC800, 16'd16, 32'd1300, 1);           // before start, must stay
        put_desc(136, 16'h8000, 16'd16, 32'd1400, 1);
        put_desc(144, 16'h8002, 16'd12, 32'd1500, 1);           // offload first
        put_desc(152, 16'hB800, 16'd10, 32'd1600, 1);           // last wrap irq
        run_walk(128, 128 + 16 + 3, 1, 1, "R1");
        chk(got_q.size() == 64, "R5", "stripped frame padded to 64", got_q.size(), 64);
        if (got_q.size() == 64)
            chk(got_q[0] == {1'b0, rmem[1508]}, "R6", "first byte after control block", got_q[0], rmem[1508]);
        w = {mem[128], mem[129]};
        chk(w == 16'hC800, "R2", "descriptor before start untouched", w, 16'hC800);

        // random rings
        for (int r = 0; r < 14; r++) begin
            int base, nd, st;
            bit be;
            logic [15:0] fl;
            base = 64 * ($urandom % 4) + 256 * (r % 2);
            nd = 2 + $urandom % 7;
            st = $urandom % nd;
            be = $urandom % 2;
            for (int d = 0; d < nd; d++) begin
                fl = 16'($urandom) & 16'h03BD;
                if ($urandom % 4 != 0) fl[15] = 1;
                if ($urandom % 3 == 0) fl[14] = 1;
                if ($urandom % 2 == 0) fl[12] = 1;
                if ($urandom % 3 == 0) fl[11] = 1;
                if ($urandom % 3 == 0) fl[1] = 1;
                if (d == nd - 1) begin
                    fl[15] = 1; fl[11] = 1; fl[13] = 1;
                    put_desc(base + 8 * d, fl, 16'(9 + $urandom % 32), 1024 + $urandom % 2900, be);
                end else
                    put_desc(base + 8 * d, fl, 16'($urandom % 40), 1024 + $urandom % 2900, be);
            end
            run_walk(base, base + 8 * st + ($urandom % 8), be, ($urandom % 4) == 0, "R4");
        end

        chk(misalign == 0, "R11", "misaligned memory requests", misalign, 0);
        report();
    end
endmodule